// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block is the device-side command interpreter of a parallel NOR-style flash. It watches single-cycle bus writes (address, data byte, write strobe) and recognises the key sequences that unlock programming and erasing. A completed program sequence produces a program request carrying the target address and data byte. A completed chip-erase or sector-erase sequence produces an erase request. The block also keeps a fast-programming bypass mode. In that mode a two-write program sequence replaces the full key sequence.

Both requests leave the block on valid/ready channels. A request stays asserted, with a stable payload, until the consumer raises ready in the same cycle. It drops on the clock edge that completes the transfer. While a request is waiting, or while the external embedded-algorithm `busy` input is high, every bus write is discarded. A plain mode pin tells the read path whether to return array data or status.

The key cycles are address 555h with data AAh, then address 2AAh with data 55h. Only the low `KEY_BITS` address bits are compared. The command byte of a standard sequence is also written to 555h.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset there is no program or erase request, `in_bypass` is 0 and `rd_status` is 0 (array reads).
- R2: The writes 555h/AAh, 2AAh/55h, 555h/A0h and then any address/data raise `prog_valid` one clock after the last write, with `prog_addr`/`prog_data` equal to that last write.
- R3: A write that breaks a key or command cycle returns the decoder to its idle state. The address compare uses only the low `KEY_BITS` address bits, so the upper bits are don't-care.
- R4: The key cycles followed by 555h/20h set `in_bypass` to 1 one clock after the third write.
- R5: In bypass mode, a write of data A0h (any address) followed by any address/data raises a program request for that address/data. `in_bypass` stays 1.
- R6: In bypass mode, a write with data other than A0h or 90h has no effect: no request is raised and `in_bypass` stays 1.
- R7: In bypass mode, data 90h followed by data 00h (addresses don't-care) clears `in_bypass`. After that, a lone A0h plus an address/data write raises no request.
- R8: The six writes 555h/AAh, 2AAh/55h, 555h/80h, 555h/AAh, 2AAh/55h, 555h/10h raise `erase_valid` with `erase_chip`=1 and `erase_addr`=0.
- R9: The same framing with a final write of data 30h at sector address S raises `erase_valid` with `erase_chip`=0 and `erase_addr`=S.
- R10: While `busy` is 1, every write is ignored: the sequence state does not advance and no request is raised.
- R11: A pending request holds valid and its payload until ready is seen. It clears on that edge. Writes arriving while it is pending are ignored.
- R12: `rd_status` is 1 whenever `busy` is 1 or a program or erase request is pending, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | One-cycle bus write strobe |
| wr_addr | input | ADDR_W | Bus write address |
| wr_data | input | 8 | Bus write data byte |
| busy | input | 1 | Embedded algorithm running |
| prog_valid | output | 1 | Program request pending |
| prog_ready | input | 1 | Program consumer accepts |
| prog_addr | output | ADDR_W | Address to program |
| prog_data | output | 8 | Byte to program |
| erase_valid | output | 1 | Erase request pending |
| erase_ready | input | 1 | Erase consumer accepts |
| erase_chip | output | 1 | 1 = whole chip, 0 = one sector |
| erase_addr | output | ADDR_W | Sector address (0 for chip erase) |
| in_bypass | output | 1 | Bypass programming mode active |
| rd_status | output | 1 | 1 = reads return status, 0 = array |

## Verification
The bench builds the decoder with `ADDR_W` = 16 and `KEY_BITS` = 12. This leaves four upper address bits outside the key compare. Key cycles can then be written at addresses such as F555h and A2AAh, which exercises the don't-care upper bits. Sector addresses and program targets with those bits set also show that the full address passes to the payload. Holding `prog_ready` and `erase_ready` low for several cycles lets the bench observe the stall window, and the writes it ignores, at the ports.

// File: rtl/fcd_pkg.sv
package fcd_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_KEY1, ST_KEY2, ST_PGM,
    ST_EKEY0, ST_EKEY1, ST_ECMD,
    ST_BYP, ST_BPGM, ST_BEXIT
  } fcd_state_e;

  localparam logic [7:0] KEY_DATA1   = 8'hAA;
  localparam logic [7:0] KEY_DATA2   = 8'h55;
  localparam logic [7:0] OP_PROGRAM  = 8'hA0;
  localparam logic [7:0] OP_SETUP    = 8'h80;
  localparam logic [7:0] OP_CHIP     = 8'h10;
  localparam logic [7:0] OP_SECTOR   = 8'h30;
  localparam logic [7:0] OP_BYP_IN   = 8'h20;
  localparam logic [7:0] OP_BYP_OUT1 = 8'h90;
  localparam logic [7:0] OP_BYP_OUT2 = 8'h00;
endpackage

// File: rtl/fcd_key_match.sv
module fcd_key_match #(
  parameter int KEY_BITS = 12,
  parameter logic [KEY_BITS-1:0] KEY_ADDR1 = 'h555,
  parameter logic [KEY_BITS-1:0] KEY_ADDR2 = 'h2AA
) (
  input  logic [KEY_BITS-1:0] addr_lo,
  input  logic [7:0]          data,
  output logic                hit_key1,
  output logic                hit_key2,
  output logic                at_cmd_addr
);
  import fcd_pkg::*;

  always_comb begin
    at_cmd_addr = (addr_lo == KEY_ADDR1);
    hit_key1    = at_cmd_addr && (data == KEY_DATA1);
    hit_key2    = (addr_lo == KEY_ADDR2) && (data == KEY_DATA2);
  end
endmodule

// File: rtl/fcd_seq_fsm.sv
module fcd_seq_fsm (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       take,
  input  logic [7:0] data,
  input  logic       hit_key1,
  input  logic       hit_key2,
  input  logic       at_cmd_addr,
  output logic       fire_prog,
  output logic       fire_chip,
  output logic       fire_sect,
  output logic       bypass_on
);
  import fcd_pkg::*;

  fcd_state_e st, st_nxt;

  always_comb begin
    st_nxt    = st;
    fire_prog = 1'b0;
    fire_chip = 1'b0;
    fire_sect = 1'b0;
    if (take) begin
      case (st)
        ST_IDLE:  st_nxt = hit_key1 ? ST_KEY1 : ST_IDLE;
        ST_KEY1:  st_nxt = hit_key2 ? ST_KEY2 : ST_IDLE;
        ST_KEY2: begin
          st_nxt = ST_IDLE;
          if (at_cmd_addr) begin
            case (data)
              OP_PROGRAM: st_nxt = ST_PGM;
              OP_SETUP:   st_nxt = ST_EKEY0;
              OP_BYP_IN:  st_nxt = ST_BYP;
              default:    st_nxt = ST_IDLE;
            endcase
          end
        end
        ST_PGM: begin
          fire_prog = 1'b1;
          st_nxt    = ST_IDLE;
        end
        ST_EKEY0: st_nxt = hit_key1 ? ST_EKEY1 : ST_IDLE;
        ST_EKEY1: st_nxt = hit_key2 ? ST_ECMD : ST_IDLE;
        ST_ECMD: begin
          st_nxt = ST_IDLE;
          if (at_cmd_addr && data == OP_CHIP) fire_chip = 1'b1;
          else if (data == OP_SECTOR)         fire_sect = 1'b1;
        end
        ST_BYP: begin
          if (data == OP_PROGRAM)       st_nxt = ST_BPGM;
          else if (data == OP_BYP_OUT1) st_nxt = ST_BEXIT;
        end
        ST_BPGM: begin
          fire_prog = 1'b1;
          st_nxt    = ST_BYP;
        end
        ST_BEXIT: st_nxt = (data == OP_BYP_OUT2) ? ST_IDLE : ST_BYP;
        default:  st_nxt = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st <= ST_IDLE;
    else        st <= st_nxt;
  end

  assign bypass_on = (st == ST_BYP) || (st == ST_BPGM) || (st == ST_BEXIT);
endmodule

// File: rtl/fcd_req_slot.sv
module fcd_req_slot #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_data,
  input  logic         ready,
  output logic         valid,
  output logic [W-1:0] payload
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid   <= 1'b0;
      payload <= '0;
    end else if (load) begin
      valid   <= 1'b1;
      payload <= load_data;
    end else if (valid && ready) begin
      valid <= 1'b0;
    end
  end
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder #(
  parameter int ADDR_W   = 20,
  parameter int KEY_BITS = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              busy,
  output logic              prog_valid,
  input  logic              prog_ready,
  output logic [ADDR_W-1:0] prog_addr,
  output logic [7:0]        prog_data,
  output logic              erase_valid,
  input  logic              erase_ready,
  output logic              erase_chip,
  output logic [ADDR_W-1:0] erase_addr,
  output logic              in_bypass,
  output logic              rd_status
);
  localparam int PW = ADDR_W + 8;
  localparam int EW = ADDR_W + 1;

  logic take, hit_key1, hit_key2, at_cmd_addr;
  logic fire_prog, fire_chip, fire_sect;
  logic [PW-1:0] prog_pl;
  logic [EW-1:0] erase_pl, erase_ld;

  assign take = wr_en && !busy && !prog_valid && !erase_valid;

  fcd_key_match #(
    .KEY_BITS(KEY_BITS),
    .KEY_ADDR1(KEY_BITS'('h555)),
    .KEY_ADDR2(KEY_BITS'('h2AA))
  ) u_match (
    .addr_lo    (wr_addr[KEY_BITS-1:0]),
    .data       (wr_data),
    .hit_key1   (hit_key1),
    .hit_key2   (hit_key2),
    .at_cmd_addr(at_cmd_addr)
  );

  fcd_seq_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .take       (take),
    .data       (wr_data),
    .hit_key1   (hit_key1),
    .hit_key2   (hit_key2),
    .at_cmd_addr(at_cmd_addr),
    .fire_prog  (fire_prog),
    .fire_chip  (fire_chip),
    .fire_sect  (fire_sect),
    .bypass_on  (in_bypass)
  );

  fcd_req_slot #(.W(PW)) u_prog (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (fire_prog),
    .load_data({wr_addr, wr_data}),
    .ready    (prog_ready),
    .valid    (prog_valid),
    .payload  (prog_pl)
  );

  assign erase_ld = fire_chip ? {1'b1, {ADDR_W{1'b0}}} : {1'b0, wr_addr};

  fcd_req_slot #(.W(EW)) u_erase (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (fire_chip || fire_sect),
    .load_data(erase_ld),
    .ready    (erase_ready),
    .valid    (erase_valid),
    .payload  (erase_pl)
  );

  assign prog_addr  = prog_pl[PW-1:8];
  assign prog_data  = prog_pl[7:0];
  assign erase_chip = erase_pl[EW-1];
  assign erase_addr = erase_pl[ADDR_W-1:0];
  assign rd_status  = busy || prog_valid || erase_valid;
endmodule

// File: rtl/fcd_checker.sv
module fcd_checker #(
  parameter int ADDR_W = 20
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [7:0]        wr_data,
  input logic              busy,
  input logic              prog_valid,
  input logic              prog_ready,
  input logic [ADDR_W-1:0] prog_addr,
  input logic [7:0]        prog_data,
  input logic              erase_valid,
  input logic              erase_ready,
  input logic              erase_chip,
  input logic [ADDR_W-1:0] erase_addr,
  input logic              in_bypass,
  input logic              rd_status
);
  // R11
  prog_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prog_valid && !prog_ready |=> prog_valid && $stable(prog_addr) && $stable(prog_data));
  // R11
  erase_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    erase_valid && !erase_ready |=> erase_valid && $stable(erase_chip) && $stable(erase_addr));
  // R10
  busy_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !$rose(prog_valid) && !$rose(erase_valid));
  // R11
  one_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({prog_valid, erase_valid}));
  // R12
  busy_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> rd_status);
  // R4
  bypass_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_bypass) |-> $past(wr_en && wr_data == 8'h20));
  // R7
  bypass_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(in_bypass) |-> $past(wr_en && wr_data == 8'h00));
endmodule

bind flash_cmd_decoder fcd_checker #(.ADDR_W(ADDR_W)) u_fcd_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .busy(busy),
  .prog_valid(prog_valid), .prog_ready(prog_ready), .prog_addr(prog_addr),
  .prog_data(prog_data), .erase_valid(erase_valid), .erase_ready(erase_ready),
  .erase_chip(erase_chip), .erase_addr(erase_addr), .in_bypass(in_bypass),
  .rd_status(rd_status)
);

// File: tb/flash_cmd_decoder_test.sv
module flash_cmd_decoder_test;
  localparam int AW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic busy = 1'b0;
  logic prog_ready = 1'b0;
  logic erase_ready = 1'b0;
  logic prog_valid, erase_valid, erase_chip, in_bypass, rd_status;
  logic [AW-1:0] prog_addr, erase_addr;
  logic [7:0] prog_data;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  flash_cmd_decoder #(.ADDR_W(AW), .KEY_BITS(12)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .busy(busy), .prog_valid(prog_valid), .prog_ready(prog_ready),
    .prog_addr(prog_addr), .prog_data(prog_data), .erase_valid(erase_valid),
    .erase_ready(erase_ready), .erase_chip(erase_chip), .erase_addr(erase_addr),
    .in_bypass(in_bypass), .rd_status(rd_status)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // one write, driven at a falling edge; returns at the next falling edge
  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic keys();
    wr(16'h0555, 8'hAA);
    wr(16'h02AA, 8'h55);
  endtask

  task automatic take_prog();
    prog_ready = 1'b1;
    @(negedge clk);
    prog_ready = 1'b0;
  endtask

  task automatic take_erase();
    erase_ready = 1'b1;
    @(negedge clk);
    erase_ready = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 prog_valid", prog_valid, 0);
    chk("R1 erase_valid", erase_valid, 0);
    chk("R1 in_bypass", in_bypass, 0);
    chk("R1 rd_status", rd_status, 0);
  endtask

  task automatic t_std_prog();
    keys();
    wr(16'h0555, 8'hA0);
    wr(16'hB3C1, 8'h5E);
    chk("R2 prog_valid", prog_valid, 1);
    chk("R2 prog_addr", prog_addr, 16'hB3C1);
    chk("R2 prog_data", prog_data, 8'h5E);
    chk("R12 status pending", rd_status, 1);
    idle(2);
    wr(16'h0555, 8'hAA);  // ignored while pending
    chk("R11 hold valid", prog_valid, 1);
    chk("R11 hold addr", prog_addr, 16'hB3C1);
    take_prog();
    chk("R11 cleared", prog_valid, 0);
    chk("R12 status idle", rd_status, 0);
    wr(16'h02AA, 8'h55);
    wr(16'h0555, 8'hA0);
    wr(16'h0042, 8'h11);
    chk("R11 pending write ignored", prog_valid, 0);
  endtask

  task automatic t_mismatch();
    wr(16'h0555, 8'hAA);
    wr(16'h02AA, 8'h54);
    wr(16'h0555, 8'hA0);
    wr(16'h0100, 8'h22);
    chk("R3 broken key", prog_valid, 0);
    wr(16'hF555, 8'hAA);
    wr(16'hA2AA, 8'h55);
    wr(16'h3555, 8'hA0);
    wr(16'h0200, 8'h33);
    chk("R3 upper bits ignored", prog_valid, 1);
    chk("R3 addr", prog_addr, 16'h0200);
    take_prog();
  endtask

  task automatic t_bypass();
    keys();
    wr(16'h0555, 8'h20);
    chk("R4 bypass entered", in_bypass, 1);
    wr(16'h7001, 8'hA0);
    wr(16'h1234, 8'h3C);
    chk("R5 bypass prog valid", prog_valid, 1);
    chk("R5 bypass prog addr", prog_addr, 16'h1234);
    chk("R5 bypass prog data", prog_data, 8'h3C);
    chk("R5 still bypass", in_bypass, 1);
    take_prog();
    wr(16'h0555, 8'h80);
    wr(16'h0555, 8'h10);
    wr(16'h0555, 8'hAA);
    wr(16'h0999, 8'h44);
    chk("R6 no prog", prog_valid, 0);
    chk("R6 no erase", erase_valid, 0);
    chk("R6 still bypass", in_bypass, 1);
    wr(16'h7777, 8'h90);
    chk("R7 after 90", in_bypass, 1);
    wr(16'h0001, 8'h00);
    chk("R7 bypass left", in_bypass, 0);
    wr(16'h0000, 8'hA0);
    wr(16'h0300, 8'h66);
    chk("R7 lone A0 ignored", prog_valid, 0);
  endtask

  task automatic t_chip();
    keys();
    wr(16'h0555, 8'h80);
    keys();
    wr(16'h0555, 8'h10);
    chk("R8 erase_valid", erase_valid, 1);
    chk("R8 erase_chip", erase_chip, 1);
    chk("R8 erase_addr", erase_addr, 0);
    idle(1);
    chk("R11 erase held", erase_valid, 1);
    take_erase();
    chk("R11 erase cleared", erase_valid, 0);
  endtask

  task automatic t_sector();
    wr(16'hF555, 8'hAA);
    wr(16'h02AA, 8'h55);
    wr(16'h0555, 8'h80);
    keys();
    wr(16'hC000, 8'h30);
    chk("R9 erase_valid", erase_valid, 1);
    chk("R9 erase_chip", erase_chip, 0);
    chk("R9 erase_addr", erase_addr, 16'hC000);
    take_erase();
  endtask

  task automatic t_busy();
    busy = 1'b1;
    @(negedge clk);
    chk("R12 status busy", rd_status, 1);
    keys();
    wr(16'h0555, 8'h20);
    chk("R10 no bypass while busy", in_bypass, 0);
    busy = 1'b0;
    wr(16'h0400, 8'h77);
    chk("R10 no prog after busy", prog_valid, 0);
    chk("R10 state not advanced", in_bypass, 0);
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_std_prog();
    t_mismatch();
    t_bypass();
    t_chip();
    t_sector();
    t_busy();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule